// File: doc/BRIEF.md
# Double-Buffered Column Operand Buffer

This block is a ping-pong data store between main memory and an 8x8 processing array. It has two sets. Each set holds two banks of 64 words of 64 bits. At any time one set is the array side's set. The array reads its operands from that set, while a memory-side port fills or drains the other set. When both sides say they are finished, the two sets swap roles. Computation on one block of data can therefore overlap the transfer of the next block.

On the array side, a column load sequencer takes a single request with a base address and a byte offset. It then delivers eight columns on eight consecutive cycles over a 128-bit bus, so one request loads the whole array. Each column beat joins the same-address words of the two banks in the chosen set. Before they are joined, each word goes through a byte-rotating shifter, which aligns the data to a byte address.

Top module: `fb_pingpong`

## Requirements
- R1: After reset, `active_set` is 0, `arr_ready` and `mem_ready` are 1, and `col_valid`, `mem_err` and `mem_rvalid` are 0.
- R2: A memory-side access whose `mem_set` differs from `active_set` is granted. A write stores `mem_wdata` into bank `mem_bank` at `mem_addr`. A read returns that word on `mem_rdata`, with `mem_rvalid` high, in the cycle after the request edge.
- R3: A memory-side access whose `mem_set` equals `active_set` is rejected. `mem_err` is high in the following cycle, a write stores nothing, and `mem_rvalid` stays low.
- R4: `arr_done` and `mem_done` pulses are remembered until a swap. `active_set` toggles at the edge where the later of the two is sampled, or where both arrive together. Both remembered flags then clear.
- R5: From the cycle after `arr_done` until the swap, `arr_ready` is 0. From the cycle after `mem_done` until the swap, `mem_ready` is 0.
- R6: The sequencer must be idle when `load_req` is sampled. In that case, the 8 cycles after the next edge carry `col_valid`=1 with `col_idx` running 0 to 7, and `col_last`=1 only on index 7. Then `col_valid` returns to 0.
- R7: Column k carries the words at address (`load_base`+k) mod 64. The bank-1 word forms bits 127:64 and the bank-0 word forms bits 63:0. Row r of the column therefore receives bits [8r+7:8r] and [8r+71:8r+64]. Each word is rotated so that output byte i is input byte (i+`load_off`) mod 8.
- R8: A `load_req` sampled while the sequencer is busy is ignored. No extra column beats follow the current sequence.
- R9: The set read by a sequence is the `active_set` value when the request was accepted. A swap during the sequence does not change the data source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | input | 1 | Memory-side access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_set | input | 1 | Set targeted by the access |
| mem_bank | input | 1 | Bank within the set |
| mem_addr | input | 6 | Word address |
| mem_wdata | input | 64 | Write data |
| mem_rdata | output | 64 | Read data |
| mem_rvalid | output | 1 | Read data valid |
| mem_err | output | 1 | Access to the array-side set was rejected |
| mem_done | input | 1 | Memory side finished with its set |
| mem_ready | output | 1 | Memory side not waiting for a swap |
| arr_done | input | 1 | Array side finished with its set |
| arr_ready | output | 1 | Array side not waiting for a swap |
| active_set | output | 1 | Set owned by the array side |
| load_req | input | 1 | Start an eight-column load |
| load_base | input | 6 | Address of column 0 |
| load_off | input | 3 | Byte rotation amount |
| col_valid | output | 1 | Column beat valid |
| col_idx | output | 3 | Column index of the beat |
| col_last | output | 1 | Final column of the sequence |
| col_data | output | 128 | Column operands, two bytes per row |

## Verification
Two situations can fall in the same cycle. In the first, a swap completes in the same cycle as a memory-side write. The bench provokes this by driving `mem_done` together with a write to the set that is inactive just before the swap. The write must be granted with no error, because the decision uses the set ownership from before the edge. A later column load from that set, now owned by the array, must return the new word. In the second, a swap completes while a column load is in progress. The bench fires both done pulses together in the middle of a sequence. It then checks that the remaining beats still come from the latched set while `active_set` toggles.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int FB_WORD_W = 64;
  localparam int FB_BYTES  = FB_WORD_W / 8;

  // Byte i of the result is byte (i + off) mod FB_BYTES of the input word.
  function automatic logic [FB_WORD_W-1:0] byte_align(input logic [FB_WORD_W-1:0] w,
                                                      input logic [2:0] off);
    logic [FB_WORD_W-1:0] r;
    r = '0;
    for (int i = 0; i < FB_BYTES; i++) begin
      r[8*i +: 8] = w[8*((i + int'(off)) % FB_BYTES) +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/fb_bank.sv
module fb_bank #(
  parameter int DEPTH = 64,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          mrd_en,
  input  logic [AW-1:0] maddr,
  output logic [W-1:0]  mrdata,
  input  logic          ard_en,
  input  logic [AW-1:0] aaddr,
  output logic [W-1:0]  ardata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (mrd_en) mrdata <= store[maddr];
    if (ard_en) ardata <= store[aaddr];
  end
endmodule

// File: rtl/fb_swap_ctl.sv
module fb_swap_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic arr_done,
  input  logic mem_done,
  output logic active_set,
  output logic arr_ready,
  output logic mem_ready,
  output logic swap_fire
);
  logic arr_flag, mem_flag;

  assign swap_fire = (arr_flag | arr_done) & (mem_flag | mem_done);
  assign arr_ready = ~arr_flag;
  assign mem_ready = ~mem_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_set <= 1'b0;
      arr_flag   <= 1'b0;
      mem_flag   <= 1'b0;
    end else if (swap_fire) begin
      active_set <= ~active_set;
      arr_flag   <= 1'b0;
      mem_flag   <= 1'b0;
    end else begin
      arr_flag <= arr_flag | arr_done;
      mem_flag <= mem_flag | mem_done;
    end
  end
endmodule

// File: rtl/fb_col_seq.sv
module fb_col_seq #(
  parameter int DEPTH = 64,
  parameter int NCOL  = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(NCOL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic [AW-1:0] load_base,
  input  logic [2:0]    load_off,
  input  logic          active_set,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rd_set,
  output logic          col_valid,
  output logic [CW-1:0] col_idx,
  output logic          col_last,
  output logic [2:0]    out_off,
  output logic          out_set,
  output logic          accept
);
  logic          busy;
  logic [CW-1:0] cnt;
  logic [AW-1:0] base_l;
  logic [2:0]    off_l;
  logic          set_l;
  logic          at_end;

  assign accept  = load_req & ~busy;
  assign at_end  = (cnt == CW'(NCOL - 1));
  assign rd_en   = busy;
  assign rd_addr = base_l + AW'(cnt);
  assign rd_set  = set_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      base_l <= '0;
      off_l  <= '0;
      set_l  <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= '0;
      base_l <= load_base;
      off_l  <= load_off;
      set_l  <= active_set;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (at_end) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_idx   <= '0;
      col_last  <= 1'b0;
      out_off   <= '0;
      out_set   <= 1'b0;
    end else begin
      col_valid <= busy;
      col_idx   <= cnt;
      col_last  <= busy & at_end;
      out_off   <= off_l;
      out_set   <= set_l;
    end
  end
endmodule

// File: rtl/fb_pingpong.sv
module fb_pingpong #(
  parameter int DEPTH = 64,
  parameter int NCOL  = 8,
  localparam int W    = fb_pkg::FB_WORD_W,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(NCOL),
  localparam int NBANK = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_req,
  input  logic            mem_we,
  input  logic            mem_set,
  input  logic            mem_bank,
  input  logic [AW-1:0]   mem_addr,
  input  logic [W-1:0]    mem_wdata,
  output logic [W-1:0]    mem_rdata,
  output logic            mem_rvalid,
  output logic            mem_err,
  input  logic            mem_done,
  output logic            mem_ready,
  input  logic            arr_done,
  output logic            arr_ready,
  output logic            active_set,
  input  logic            load_req,
  input  logic [AW-1:0]   load_base,
  input  logic [2:0]      load_off,
  output logic            col_valid,
  output logic [CW-1:0]   col_idx,
  output logic            col_last,
  output logic [2*W-1:0]  col_data
);
  logic             swap_fire;
  logic             mem_grant;
  logic [NBANK-1:0] bank_we;
  logic [W-1:0]     mrd [NBANK];
  logic [W-1:0]     ard [NBANK];
  logic [1:0]       rsel_q;
  logic             rd_en, rd_set, out_set, accept;
  logic [AW-1:0]    rd_addr;
  logic [2:0]       out_off;

  assign mem_grant = mem_req & (mem_set != active_set);

  fb_swap_ctl u_swap (
    .clk(clk), .rst_n(rst_n), .arr_done(arr_done), .mem_done(mem_done),
    .active_set(active_set), .arr_ready(arr_ready), .mem_ready(mem_ready),
    .swap_fire(swap_fire)
  );

  fb_col_seq #(.DEPTH(DEPTH), .NCOL(NCOL)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_base(load_base),
    .load_off(load_off), .active_set(active_set), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_set(rd_set), .col_valid(col_valid),
    .col_idx(col_idx), .col_last(col_last), .out_off(out_off),
    .out_set(out_set), .accept(accept)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic G_SET  = 1'(g / 2);
    localparam logic G_BANK = 1'(g % 2);
    assign bank_we[g] = mem_grant & mem_we & (mem_set == G_SET) & (mem_bank == G_BANK);
    fb_bank #(.DEPTH(DEPTH), .W(W)) u_bank (
      .clk(clk), .we(bank_we[g]), .waddr(mem_addr), .wdata(mem_wdata),
      .mrd_en(mem_grant & ~mem_we & (mem_set == G_SET) & (mem_bank == G_BANK)),
      .maddr(mem_addr), .mrdata(mrd[g]),
      .ard_en(rd_en & (rd_set == G_SET)), .aaddr(rd_addr), .ardata(ard[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_err    <= 1'b0;
      mem_rvalid <= 1'b0;
      rsel_q     <= '0;
    end else begin
      mem_err    <= mem_req & ~mem_grant;
      mem_rvalid <= mem_grant & ~mem_we;
      rsel_q     <= {mem_set, mem_bank};
    end
  end

  assign mem_rdata = mrd[rsel_q];
  assign col_data  = {fb_pkg::byte_align(ard[{out_set, 1'b1}], out_off),
                      fb_pkg::byte_align(ard[{out_set, 1'b0}], out_off)};
endmodule

// File: rtl/fb_pingpong_chk.sv
module fb_pingpong_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_set,
  input logic          active_set,
  input logic          mem_err,
  input logic          swap_fire,
  input logic          arr_done,
  input logic          arr_ready,
  input logic          mem_done,
  input logic          mem_ready,
  input logic          col_valid,
  input logic [CW-1:0] col_idx,
  input logic          col_last,
  input logic [3:0]    bank_we
);
  a_r4_swap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |=> active_set != $past(active_set));
  a_r4_hold_without_swap: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_fire |=> $stable(active_set));
  a_r3_active_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_set == active_set) |=> mem_err);
  a_r3_no_write_active: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we[{active_set, 1'b0}] && !bank_we[{active_set, 1'b1}]);
  a_r2_one_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
  a_r5_arr_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_done && !swap_fire) |=> !arr_ready);
  a_r5_mem_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done && !swap_fire) |=> !mem_ready);
  a_r6_last_index: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_last) |-> col_idx == CW'(7));
  a_r6_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last) |=> (col_valid && col_idx == $past(col_idx) + 1'b1));
endmodule

bind fb_pingpong fb_pingpong_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_set(mem_set),
  .active_set(active_set), .mem_err(mem_err), .swap_fire(swap_fire),
  .arr_done(arr_done), .arr_ready(arr_ready), .mem_done(mem_done),
  .mem_ready(mem_ready), .col_valid(col_valid), .col_idx(col_idx),
  .col_last(col_last), .bank_we(bank_we)
);

// File: tb/fb_pingpong_tb.sv
module fb_pingpong_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_req = 0, mem_we = 0, mem_set = 0, mem_bank = 0;
  logic [5:0] mem_addr = '0;
  logic [63:0] mem_wdata = '0, mem_rdata;
  logic mem_rvalid, mem_err, mem_done = 0, mem_ready, arr_done = 0, arr_ready, active_set;
  logic load_req = 0;
  logic [5:0] load_base = '0;
  logic [2:0] load_off = '0;
  logic col_valid, col_last;
  logic [2:0] col_idx;
  logic [127:0] col_data;

  int n_chk = 0, n_fail = 0;
  logic [63:0] mdl [4][64];
  bit exp_act = 0;

  always #10 clk = ~clk;

  fb_pingpong dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rot(input logic [63:0] w, input logic [2:0] off);
    logic [127:0] d;
    d = {w, w} >> (8 * off);
    return d[63:0];
  endfunction

  function automatic logic [127:0] exp_col(input bit s, input logic [5:0] a, input logic [2:0] off);
    return {rot(mdl[2*s+1][a], off), rot(mdl[2*s][a], off)};
  endfunction

  task automatic mem_wr(input bit s, input bit b, input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    mem_req = 1; mem_we = 1; mem_set = s; mem_bank = b; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_req = 0; mem_we = 0;
    chk(mem_err == (s == exp_act), (s == exp_act) ? "R3 write err" : "R2 write no err",
        128'(mem_err), 128'(s == exp_act));
    if (s != exp_act) mdl[2*s+b][a] = d;
  endtask

  task automatic mem_rd(input bit s, input bit b, input logic [5:0] a);
    @(negedge clk);
    mem_req = 1; mem_we = 0; mem_set = s; mem_bank = b; mem_addr = a;
    @(negedge clk);
    mem_req = 0;
    if (s == exp_act) begin
      chk(mem_err && !mem_rvalid, "R3 read rejected", {mem_err, mem_rvalid}, 2'b10);
    end else begin
      chk(mem_rvalid && !mem_err, "R2 read valid", {mem_err, mem_rvalid}, 2'b01);
      chk(mem_rdata == mdl[2*s+b][a], "R2 read data", 128'(mem_rdata), 128'(mdl[2*s+b][a]));
    end
  endtask

  // arr_done first, then mem_done; checks R4 and R5 along the way
  task automatic swap_seq();
    @(negedge clk); arr_done = 1;
    @(negedge clk); arr_done = 0;
    chk(!arr_ready && mem_ready, "R5 arr waits", {arr_ready, mem_ready}, 2'b01);
    chk(active_set == exp_act, "R4 no early swap", 128'(active_set), 128'(exp_act));
    @(negedge clk); mem_done = 1;
    @(negedge clk); mem_done = 0;
    exp_act = ~exp_act;
    chk(active_set == exp_act, "R4 swap", 128'(active_set), 128'(exp_act));
    chk(arr_ready && mem_ready, "R5 ready again", {arr_ready, mem_ready}, 2'b11);
  endtask

  // stray: 1 = pulse load_req at beat 2; midswap: both done pulses at beat 3
  task automatic run_load(input logic [5:0] base, input logic [2:0] off, input bit stray, input bit midswap);
    bit s;
    s = exp_act;
    @(negedge clk);
    load_req = 1; load_base = base; load_off = off;
    @(negedge clk);
    load_req = 0;
    chk(!col_valid, "R6 no beat yet", 128'(col_valid), 0);
    for (int k = 0; k < 8; k++) begin
      if (stray && k == 2) begin load_req = 1; load_base = 6'h0; end
      if (midswap && k == 3) begin arr_done = 1; mem_done = 1; end
      @(negedge clk);
      load_req = 0; arr_done = 0;
      mem_done = 0;
      if (midswap && k == 3) exp_act = ~exp_act;
      chk(col_valid && col_idx == 3'(k) && col_last == (k == 7), "R6 beat",
          {col_valid, col_idx, col_last}, {1'b1, 3'(k), (k == 7)});
      chk(col_data == exp_col(s, base + 6'(k), off), midswap ? "R9 latched set" : "R7 column data",
          col_data, exp_col(s, base + 6'(k), off));
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!col_valid, stray ? "R8 busy request ignored" : "R6 sequence ends", 128'(col_valid), 0);
    end
    if (midswap) chk(active_set == exp_act, "R9 swap during load", 128'(active_set), 128'(exp_act));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(active_set == 0 && arr_ready && mem_ready, "R1 swap state", {active_set, arr_ready, mem_ready}, 3'b011);
    chk(!col_valid && !mem_err && !mem_rvalid, "R1 outputs idle", {col_valid, mem_err, mem_rvalid}, 0);

    // fill set 1 while set 0 is the array's
    for (int a = 0; a < 64; a++) begin
      mem_wr(1, 0, 6'(a), {$urandom, $urandom});
      mem_wr(1, 1, 6'(a), {$urandom, $urandom});
    end
    for (int i = 0; i < 6; i++) mem_rd(1, 1'($urandom), 6'($urandom));
    mem_rd(0, 0, 6'd3);
    swap_seq();
    run_load(6'd60, 3'd3, 1'b0, 1'b0);     // address wrap
    run_load(6'd17, 3'd0, 1'b1, 1'b0);     // R8 stray request

    // fill set 0, reject writes to set 1
    for (int a = 0; a < 64; a++) begin
      mem_wr(0, 0, 6'(a), {$urandom, $urandom});
      mem_wr(0, 1, 6'(a), {$urandom, $urandom});
    end
    mem_wr(1, 0, 6'd5, 64'hdead_beef_dead_beef);
    mem_wr(1, 1, 6'd5, 64'hcafe_cafe_cafe_cafe);
    run_load(6'd2, 3'd7, 1'b0, 1'b0);      // R3: address 5 unchanged at beat 3
    run_load(6'd40, 3'd5, 1'b0, 1'b1);     // R9: swap mid-load, active becomes 0

    // swap completes in the same cycle as a write to the inactive set
    @(negedge clk); arr_done = 1;
    @(negedge clk); arr_done = 0;
    mem_req = 1; mem_we = 1; mem_set = 1; mem_bank = 0; mem_addr = 6'd9;
    mem_wdata = 64'h0102_0304_0506_0708; mem_done = 1;
    @(negedge clk);
    mem_req = 0; mem_we = 0; mem_done = 0;
    chk(!mem_err, "R2 write at swap edge", 128'(mem_err), 0);
    mdl[2][9] = 64'h0102_0304_0506_0708;
    exp_act = 1;
    chk(active_set == 1, "R4 swap with write", 128'(active_set), 1);
    run_load(6'd9, 3'd1, 1'b0, 1'b0);

    for (int i = 0; i < 6; i++) run_load(6'($urandom), 3'($urandom), 1'b0, 1'b0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule